// File: doc/BRIEF.md
# Configurable edge-triggered event detector

This block watches a bank of asynchronous event lines and turns selected transitions on them into latched requests. Every line is first brought into the system clock domain through a chain of flip-flops. It is then compared with its own value one cycle earlier to find rising and falling transitions. Two enable registers choose, per line, which transition direction counts. A qualifying transition raises a one-cycle event pulse on that line and sets a sticky pending flag. The OR of all pending flags forms a single interrupt request.

Software reaches the three registers through a simple write/read port. Only a sparse set of bit positions are real lines, chosen by a mask parameter. All other positions ignore writes and read as zero. A pending flag is cleared by writing a one to its position. A transition that coincides with a write to either enable register is discarded. This keeps a reconfiguration from producing a spurious request.

Top module: `edge_event_unit`

## Requirements
- R1: After reset, all three registers (rising enable at address 0, falling enable at address 1, pending at address 2) read 0, `irqOut` is 0 and `evtPulse` is 0. Address 3 reads 0.
- R2: A write to address 0 or 1 stores only the implemented positions, which by default are bits 0 to 16, 21 and 22 (mask 0x0061FFFF). Other positions read back as 0.
- R3: With the rising enable bit of a line set, a 0-to-1 change on that input sets the line's pending bit. Inputs are changed between clock edges. The bit is still 0 after the second rising clock edge following the change and is 1 after the third.
- R4: With the falling enable bit of a line set, a 1-to-0 change on that input sets the line's pending bit, with the same latency as R3.
- R5: Triggering is on edges only. An input held at a steady level, or a transition whose direction is not enabled, leaves the pending bit unchanged.
- R6: When both enable bits of a line are set, each rising and each falling change sets its pending bit.
- R7: `evtPulse` is high for exactly one cycle on a line, in the same cycle that a qualifying edge sets its pending bit.
- R8: `irqOut` is 1 exactly when at least one pending bit is 1.
- R9: Writing address 2 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 are left unchanged.
- R10: An edge that reaches the pending logic in the same cycle as a write to address 0 or 1 is dropped. No pending bit is set and no event pulse is produced.
- R11: If a qualifying edge and a clearing write reach the same pending bit in the same cycle, the bit stays 1.
- R12: Edges on unimplemented positions never set a pending bit or produce an event pulse, even when all enable bits are written as ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineIn | input | 32 | Asynchronous event inputs, one per bit position |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 rising enable, 1 falling enable, 2 pending (write one to clear) |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read address, same map as writes; 3 reads zero |
| rdData | output | 32 | Read data of the addressed register |
| evtPulse | output | 32 | One-cycle pulse per line on a qualifying edge |
| irqOut | output | 1 | OR of all pending bits |

## Verification
The bench builds the block with the default mask 0x0061FFFF and a two-stage synchroniser. With that mask, unimplemented positions lie both between implemented lines (17 to 20) and above them (23 to 31), so the bench can show that both kinds stay inert. The fixed three-edge latency lets the bench line a register write up with the exact cycle in which an edge reaches the pending logic. That is what exposes the write-collision rule and the clear-versus-set priority.

// File: rtl/eeu_pkg.sv
package eeu_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_RISE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FALL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrRise;
    logic             wrFall;
    logic             wrPend;
    logic             wrTrig;
    logic [REG_W-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/eeu_sync.sv
module eeu_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chainQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chainQ[s] <= '0;
          else       chainQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chainQ[s] <= '0;
          else       chainQ[s] <= chainQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chainQ[STAGES-1];
endmodule

// File: rtl/eeu_ctrl.sv
module eeu_ctrl
  import eeu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output strobe_t           stb
);
  always_comb begin
    stb.wrRise = wrEn && (wrAddr == ADDR_RISE);
    stb.wrFall = wrEn && (wrAddr == ADDR_FALL);
    stb.wrPend = wrEn && (wrAddr == ADDR_PEND);
    stb.wrTrig = stb.wrRise || stb.wrFall;
    stb.wdata  = wrData;
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrRise, stb.wrFall, stb.wrPend}));
endmodule

// File: rtl/eeu_datapath.sv
module eeu_datapath
  import eeu_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = 32'h0061_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [REG_W-1:0]  syncIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic [REG_W-1:0]  evtPulse,
  output logic              irqOut
);
  logic [REG_W-1:0] prevQ, riseEnQ, fallEnQ, pendQ, evtQ;
  logic [REG_W-1:0] riseEdge, fallEdge, qualEdge, clrMask;

  always_comb begin
    riseEdge = syncIn & ~prevQ;
    fallEdge = ~syncIn & prevQ;
    qualEdge = ((riseEdge & riseEnQ) | (fallEdge & fallEnQ))
               & {REG_W{~stb.wrTrig}};
    clrMask  = stb.wrPend ? stb.wdata : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ   <= '0;
      riseEnQ <= '0;
      fallEnQ <= '0;
      pendQ   <= '0;
      evtQ    <= '0;
    end else begin
      prevQ <= syncIn;
      if (stb.wrRise) riseEnQ <= stb.wdata & IMPL_MASK;
      if (stb.wrFall) fallEnQ <= stb.wdata & IMPL_MASK;
      pendQ <= (pendQ & ~clrMask) | qualEdge;
      evtQ  <= qualEdge;
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_RISE: rdData = riseEnQ;
      ADDR_FALL: rdData = fallEnQ;
      ADDR_PEND: rdData = pendQ;
      default:   rdData = '0;
    endcase
  end

  assign evtPulse = evtQ;
  assign irqOut   = |pendQ;

  // R7
  evt_has_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((evtQ & ~pendQ) == '0));

  // R10
  trig_write_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrTrig |=> (evtQ == '0));

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrPend |=> ((pendQ & $past(stb.wdata) & ~evtQ) == '0));

  // R5
  pend_set_by_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & ~$past(pendQ) & ~evtQ) == '0));
endmodule

// File: rtl/edge_event_unit.sv
module edge_event_unit
  import eeu_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK   = 32'h0061_FFFF,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  lineIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic [REG_W-1:0]  evtPulse,
  output logic              irqOut
);
  strobe_t          stb;
  logic [REG_W-1:0] syncLines;

  eeu_sync #(.WIDTH(REG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(lineIn), .syncOut(syncLines)
  );

  eeu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .stb(stb)
  );

  eeu_datapath #(.IMPL_MASK(IMPL_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .syncIn(syncLines),
    .rdAddr(rdAddr), .rdData(rdData), .evtPulse(evtPulse), .irqOut(irqOut)
  );

  // R8
  irq_matches_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_PEND) |-> (irqOut == (rdData != '0)));
endmodule

// File: tb/edge_event_unit_test.sv
module edge_event_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lineIn = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData, evtPulse;
  logic        irqOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  localparam logic [31:0] MASK = 32'h0061_FFFF;

  always #2 clk = ~clk;

  edge_event_unit #(.IMPL_MASK(MASK), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .evtPulse(evtPulse), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic chkReg(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    readReg(a, v);
    chk(req, v, exp);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic t_reset();
    chkReg("R1 rise", 2'd0, 32'h0);
    chkReg("R1 fall", 2'd1, 32'h0);
    chkReg("R1 pend", 2'd2, 32'h0);
    chkReg("R1 addr3", 2'd3, 32'h0);
    chk("R1 irq", {31'b0, irqOut}, 32'h0);
    chk("R1 evt", evtPulse, 32'h0);
  endtask

  task automatic t_regmask();
    regWrite(2'd0, 32'hFFFF_FFFF);
    chkReg("R2 rise mask", 2'd0, MASK);
    regWrite(2'd1, 32'hFFFF_FFFF);
    chkReg("R2 fall mask", 2'd1, MASK);
    regWrite(2'd0, 32'h0);
    regWrite(2'd1, 32'h0);
    chkReg("R2 rise cleared", 2'd0, 32'h0);
    chkReg("R2 fall cleared", 2'd1, 32'h0);
  endtask

  task automatic t_rise();
    regWrite(2'd0, 32'h8);
    lineIn[3] = 1'b1;
    step(); step();
    chkReg("R3 not yet", 2'd2, 32'h0);
    step();
    chkReg("R3 set", 2'd2, 32'h8);
    chk("R7 pulse", evtPulse, 32'h8);
    chk("R8 irq high", {31'b0, irqOut}, 32'h1);
    step();
    chk("R7 pulse ends", evtPulse, 32'h0);
    lineIn[3] = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R5 no fall trigger evt", evtPulse, 32'h0);
    end
    chkReg("R5 pend held", 2'd2, 32'h8);
    regWrite(2'd2, 32'hFFFF_FFF7);
    chkReg("R9 zero no effect", 2'd2, 32'h8);
    regWrite(2'd2, 32'h8);
    chkReg("R9 cleared", 2'd2, 32'h0);
    chk("R8 irq low", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_fall();
    regWrite(2'd0, 32'h0);
    regWrite(2'd1, 32'h0020_0000);
    lineIn[21] = 1'b1;
    for (int i = 0; i < 4; i++) step();
    chkReg("R5 rise ignored", 2'd2, 32'h0);
    lineIn[21] = 1'b0;
    step(); step();
    chkReg("R4 not yet", 2'd2, 32'h0);
    step();
    chkReg("R4 set", 2'd2, 32'h0020_0000);
    chk("R4 evt", evtPulse, 32'h0020_0000);
    for (int i = 0; i < 4; i++) step();
    chkReg("R5 level holds", 2'd2, 32'h0020_0000);
    regWrite(2'd2, 32'h0020_0000);
    regWrite(2'd1, 32'h0);
  endtask

  task automatic t_both();
    regWrite(2'd0, 32'h1);
    regWrite(2'd1, 32'h1);
    lineIn[0] = 1'b1;
    step(); step(); step();
    chkReg("R6 rise", 2'd2, 32'h1);
    regWrite(2'd2, 32'h1);
    lineIn[0] = 1'b0;
    step(); step(); step();
    chkReg("R6 fall", 2'd2, 32'h1);
    regWrite(2'd2, 32'h1);
    regWrite(2'd0, 32'h0);
    regWrite(2'd1, 32'h0);
  endtask

  task automatic t_collision();
    regWrite(2'd0, 32'h20);
    lineIn[5] = 1'b1;
    step(); step();
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 32'h20;
    step();
    wrEn = 1'b0;
    chkReg("R10 rise write drops", 2'd2, 32'h0);
    chk("R10 no evt", evtPulse, 32'h0);
    lineIn[5] = 1'b0;
    for (int i = 0; i < 4; i++) step();
    lineIn[5] = 1'b1;
    step(); step();
    wrEn = 1'b1; wrAddr = 2'd1; wrData = 32'h0;
    step();
    wrEn = 1'b0;
    chkReg("R10 fall write drops", 2'd2, 32'h0);
    lineIn[5] = 1'b0;
    for (int i = 0; i < 4; i++) step();
    regWrite(2'd0, 32'h0);
  endtask

  task automatic t_clrwin();
    regWrite(2'd0, 32'h80);
    lineIn[7] = 1'b1;
    step(); step(); step();
    chkReg("R3 line7 set", 2'd2, 32'h80);
    regWrite(2'd1, 32'h80);
    step();
    lineIn[7] = 1'b0;
    step(); step();
    wrEn = 1'b1; wrAddr = 2'd2; wrData = 32'h80;
    step();
    wrEn = 1'b0;
    chkReg("R11 edge wins", 2'd2, 32'h80);
    chk("R11 evt", evtPulse, 32'h80);
    regWrite(2'd2, 32'h80);
    chkReg("R9 line7 cleared", 2'd2, 32'h0);
    regWrite(2'd0, 32'h0);
    regWrite(2'd1, 32'h0);
  endtask

  task automatic t_reserved();
    regWrite(2'd0, 32'hFFFF_FFFF);
    regWrite(2'd1, 32'hFFFF_FFFF);
    lineIn[18] = 1'b1;
    lineIn[30] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R12 no evt", evtPulse, 32'h0);
    end
    chkReg("R12 no pend", 2'd2, 32'h0);
    chk("R12 no irq", {31'b0, irqOut}, 32'h0);
    lineIn[18] = 1'b0;
    lineIn[30] = 1'b0;
    for (int i = 0; i < 4; i++) step();
    chkReg("R12 still none", 2'd2, 32'h0);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    t_reset();
    t_regmask();
    t_rise();
    t_fall();
    t_both();
    t_collision();
    t_clrwin();
    t_reserved();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule